// File: doc/BRIEF.md
# Dual Reference Clock Selector

This block decides which of two reference clocks feeds a downstream PLL. A free-running system clock samples both references, notes their edges, and raises a separate loss-of-signal alarm for each reference. An alarm stays set until the reference has shown activity again for a chosen number of consecutive observation windows.

A two-bit mode code picks the selection policy. In manual mode, the choice comes from an external select line that is synchronized and deglitched. The two automatic modes fail over on alarms. The revertive mode prefers the first reference. The non-revertive mode stays on whichever reference it is using until that one fails.

When both references are in alarm, the block raises a hold request so the PLL freezes its frequency. In the automatic modes the selection and the active-clock indicator keep pointing at the last reference that was in use.

Top module: `refclk_select_ctrl`

## Requirements
- R1: While reset is held low and in the first cycle after its release, `alarm_a`, `alarm_b`, `mux_sel`, `active_ind` and `hold` are all 0.
- R2: `mode_code` encoding: 0 = manual, 1 = automatic non-revertive, 2 = automatic revertive, 3 = treated as manual.
- R3: In manual mode, `mux_sel` follows the filtered `man_sel` level (0 selects reference A, 1 selects reference B), whatever the alarms are.
- R4: A new `man_sel` level is accepted only after it has been seen, past the synchronizer, on `DG_CYC` consecutive system-clock cycles. With `SYNC_STAGES`=2 a level held from cycle 0 reaches `mux_sel` after the edge `DG_CYC`+3. Shorter pulses are ignored.
- R5: A reference's alarm is set at the end of any `WIN_CYC`-cycle window in which no rising edge of that reference was detected.
- R6: A set alarm clears only at the end of the `reval_windows`-th consecutive window that contained an edge. A window with no edge restarts the count. A value of 0 acts as 1.
- R7: In revertive mode, reference A is selected (`mux_sel`=0) on the cycle after any cycle in which `alarm_a` is clear.
- R8: In non-revertive mode, the selection changes only when the current reference is in alarm and the other one is clear.
- R9: `hold` is 1 on the cycle after both alarms are set, and 0 on the cycle after they are not both set.
- R10: In the automatic modes, while both alarms are set, `mux_sel` and `active_ind` keep the last active reference.
- R11: `active_ind` always shows the same reference as `mux_sel` (0 = A, 1 = B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Monitored reference clock A |
| ref_b | input | 1 | Monitored reference clock B |
| mode_code | input | 2 | Selection policy code (R2) |
| man_sel | input | 1 | Manual select level, asynchronous |
| reval_windows | input | RV_W | Good windows needed to clear an alarm |
| alarm_a | output | 1 | Loss-of-signal alarm for reference A |
| alarm_b | output | 1 | Loss-of-signal alarm for reference B |
| active_ind | output | 1 | Active reference indicator |
| mux_sel | output | 1 | Select to the reference clock multiplexer |
| hold | output | 1 | Freeze request to the PLL |

## Verification
References are stopped and restarted in sequences that separate the revertive policy from the non-revertive one: after reference A recovers, one policy returns to it and the other stays on B. A double failure entered while B is active shows that the indicator keeps B rather than falling back to its reset value. A sweep of `reval_windows` values, including 0, brackets the recovery time between window-count bounds, which catches off-by-one errors in the revalidation count. A sweep of manual pulse widths from 1 up to one below the filter length, plus an exact-latency check on a held level, separates correct deglitching from a filter that is too short or missing.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   typedef enum logic [1:0] {
      MODE_MANUAL      = 2'd0,
      MODE_AUTO_STAY   = 2'd1,
      MODE_AUTO_REVERT = 2'd2,
      MODE_MANUAL_ALT  = 2'd3
   } sel_mode_e;

   function automatic logic mode_is_auto(input logic [1:0] code);
      return (code == MODE_AUTO_STAY) || (code == MODE_AUTO_REVERT);
   endfunction
endpackage

// File: rtl/los_monitor.sv
module los_monitor #(
   parameter int WIN_CYC     = 64,
   parameter int RV_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_BOTH   = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mon_in,
   input  logic [RV_W-1:0] reval_windows,
   output logic            alarm
);
   localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
   localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);

   logic [SYNC_STAGES:0] sh;
   logic                 edge_seen;
   logic [CW-1:0]        win_cnt;
   logic                 win_end;
   logic                 seen_q;
   logic                 seen_now;
   logic [RV_W-1:0]      good_cnt;
   logic [RV_W:0]        good_inc;
   logic [RV_W:0]        need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], mon_in};
   end

   generate
      if (EDGE_BOTH) begin : g_any_edge
         assign edge_seen = sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES];
      end else begin : g_rise_edge
         assign edge_seen = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
      end
   endgenerate

   assign win_end  = (win_cnt == WIN_LAST);
   assign seen_now = seen_q | edge_seen;
   assign good_inc = {1'b0, good_cnt} + (RV_W+1)'(1);
   assign need     = (reval_windows == '0) ? (RV_W+1)'(1) : {1'b0, reval_windows};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         seen_q   <= 1'b0;
         good_cnt <= '0;
         alarm    <= 1'b0;
      end else begin
         win_cnt <= win_end ? '0 : win_cnt + CW'(1);
         if (win_end) begin
            seen_q <= 1'b0;
            if (!seen_now) begin
               alarm    <= 1'b1;
               good_cnt <= '0;
            end else if (alarm) begin
               if (good_inc >= need) begin
                  alarm    <= 1'b0;
                  good_cnt <= '0;
               end else begin
                  good_cnt <= good_inc[RV_W-1:0];
               end
            end
         end else begin
            seen_q <= seen_now;
         end
      end
   end
endmodule

// File: rtl/sel_deglitch.sv
module sel_deglitch #(
   parameter int STABLE_CYC  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic clean_out
);
   localparam int DW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
   localparam logic [DW-1:0] CNT_LAST = DW'(STABLE_CYC - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [DW-1:0]          dcnt;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt      <= '0;
         clean_out <= 1'b0;
      end else if (synced == clean_out) begin
         dcnt <= '0;
      end else if (dcnt == CNT_LAST) begin
         dcnt      <= '0;
         clean_out <= synced;
      end else begin
         dcnt <= dcnt + DW'(1);
      end
   end
endmodule

// File: rtl/ref_select_fsm.sv
module ref_select_fsm
   import refsel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_code,
   input  logic       man_clean,
   input  logic [1:0] alarms,
   output logic       sel,
   output logic       hold
);
   sel_mode_e mode;
   logic      both_bad;
   logic      cur_bad;
   logic      oth_bad;
   logic      sel_nx;

   assign mode     = sel_mode_e'(mode_code);
   assign both_bad = alarms[0] & alarms[1];
   assign cur_bad  = sel ? alarms[1] : alarms[0];
   assign oth_bad  = sel ? alarms[0] : alarms[1];

   always_comb begin
      sel_nx = sel;
      case (mode)
         MODE_AUTO_REVERT: begin
            if (!alarms[0])      sel_nx = 1'b0;
            else if (!alarms[1]) sel_nx = 1'b1;
         end
         MODE_AUTO_STAY: begin
            if (cur_bad && !oth_bad) sel_nx = ~sel;
         end
         default: sel_nx = man_clean;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         hold <= 1'b0;
      end else begin
         sel  <= sel_nx;
         hold <= both_bad;
      end
   end
endmodule

// File: rtl/refclk_select_ctrl.sv
module refclk_select_ctrl #(
   parameter int WIN_CYC     = 64,
   parameter int DG_CYC      = 16,
   parameter int RV_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_BOTH   = 1'b0
) (
   input  logic            sys_clk,
   input  logic            rst_n,
   input  logic            ref_a,
   input  logic            ref_b,
   input  logic [1:0]      mode_code,
   input  logic            man_sel,
   input  logic [RV_W-1:0] reval_windows,
   output logic            alarm_a,
   output logic            alarm_b,
   output logic            active_ind,
   output logic            mux_sel,
   output logic            hold
);
   localparam int NUM_REF = 2;

   if (WIN_CYC < 4)     begin : g_bad_win  $error("WIN_CYC must be at least 4"); end
   if (DG_CYC < 2)      begin : g_bad_dg   $error("DG_CYC must be at least 2"); end
   if (RV_W < 1)        begin : g_bad_rv   $error("RV_W must be at least 1"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   logic [NUM_REF-1:0] refs;
   logic [NUM_REF-1:0] alarms;
   logic               man_clean;
   logic               sel_q;

   assign refs = {ref_b, ref_a};

   for (genvar i = 0; i < NUM_REF; i++) begin : g_mon
      los_monitor #(
         .WIN_CYC    (WIN_CYC),
         .RV_W       (RV_W),
         .SYNC_STAGES(SYNC_STAGES),
         .EDGE_BOTH  (EDGE_BOTH)
      ) u_mon (
         .clk          (sys_clk),
         .rst_n        (rst_n),
         .mon_in       (refs[i]),
         .reval_windows(reval_windows),
         .alarm        (alarms[i])
      );
   end

   sel_deglitch #(
      .STABLE_CYC (DG_CYC),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_dg (
      .clk      (sys_clk),
      .rst_n    (rst_n),
      .raw_in   (man_sel),
      .clean_out(man_clean)
   );

   ref_select_fsm u_fsm (
      .clk      (sys_clk),
      .rst_n    (rst_n),
      .mode_code(mode_code),
      .man_clean(man_clean),
      .alarms   (alarms),
      .sel      (sel_q),
      .hold     (hold)
   );

   assign alarm_a    = alarms[0];
   assign alarm_b    = alarms[1];
   assign mux_sel    = sel_q;
   assign active_ind = sel_q;
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker (
   input logic       sys_clk,
   input logic       rst_n,
   input logic [1:0] mode_code,
   input logic       alarm_a,
   input logic       alarm_b,
   input logic       mux_sel,
   input logic       hold
);
   p_hold_set_r9: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (alarm_a && alarm_b) |=> hold);

   p_hold_clear_r9: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !(alarm_a && alarm_b) |=> !hold);

   p_revert_pref_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (mode_code == 2'd2 && !alarm_a) |=> !mux_sel);

   p_stay_put_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (mode_code == 2'd1 && !(mux_sel ? alarm_b : alarm_a)) |=> $stable(mux_sel));

   p_hold_keeps_r10: assert property (@(posedge sys_clk) disable iff (!rst_n)
      ((mode_code == 2'd1 || mode_code == 2'd2) && alarm_a && alarm_b) |=> $stable(mux_sel));
endmodule

bind refclk_select_ctrl refsel_checker u_chk (
   .sys_clk  (sys_clk),
   .rst_n    (rst_n),
   .mode_code(mode_code),
   .alarm_a  (alarm_a),
   .alarm_b  (alarm_b),
   .mux_sel  (mux_sel),
   .hold     (hold)
);

// File: tb/tb_refclk_select_ctrl.sv
`timescale 1ns/1ps
module tb_refclk_select_ctrl;
   localparam int WIN = 16;
   localparam int DG  = 8;
   localparam int RVW = 4;

   logic sys_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic ref_a   = 1'b0;
   logic ref_b   = 1'b0;
   logic [1:0] mode_code = 2'd2;
   logic man_sel = 1'b0;
   logic [RVW-1:0] reval_windows = 4'd3;
   logic alarm_a, alarm_b, active_ind, mux_sel, hold;

   logic en_a = 1'b1, en_b = 1'b1;
   int   ph_a = 0, ph_b = 0;
   int   n_tests = 0, n_fail = 0;
   int   cyc = 0;
   bit   done = 1'b0;

   always #10 sys_clk = ~sys_clk;

   refclk_select_ctrl #(.WIN_CYC(WIN), .DG_CYC(DG), .RV_W(RVW)) dut (
      .sys_clk(sys_clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
      .mode_code(mode_code), .man_sel(man_sel), .reval_windows(reval_windows),
      .alarm_a(alarm_a), .alarm_b(alarm_b), .active_ind(active_ind),
      .mux_sel(mux_sel), .hold(hold));

   // reference A toggles every 2 cycles, B every 3 cycles, while enabled
   always @(negedge sys_clk) begin
      if (en_a) begin
         ph_a <= (ph_a == 1) ? 0 : ph_a + 1;
         if (ph_a == 1) ref_a <= ~ref_a;
      end
      if (en_b) begin
         ph_b <= (ph_b == 2) ? 0 : ph_b + 1;
         if (ph_b == 2) ref_b <= ~ref_b;
      end
   end

   always @(posedge sys_clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic wc(input int n);
      repeat (n) @(negedge sys_clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic reval_case(input int rv);
      int n;
      int eff;
      eff = (rv == 0) ? 1 : rv;
      reval_windows = RVW'(rv);
      en_b = 1'b0;
      wc(3 * WIN);
      chk("R5 alarm_b after stop", int'(alarm_b), 1);
      en_b = 1'b1;
      n = 0;
      while (alarm_b && n < 200) begin
         wc(1);
         n++;
      end
      chk("R6 alarm_b clears", int'(alarm_b), 0);
      chk("R6 recovery not early", int'(n > (eff - 1) * WIN), 1);
      chk("R6 recovery not late", int'(n <= (eff + 1) * WIN + 4), 1);
   endtask

   initial begin
      // R1: reset state
      wc(3);
      chk("R1 alarm_a in reset", int'(alarm_a), 0);
      chk("R1 alarm_b in reset", int'(alarm_b), 0);
      chk("R1 mux_sel in reset", int'(mux_sel), 0);
      chk("R1 hold in reset", int'(hold), 0);
      rst_n = 1'b1;
      wc(1);
      chk("R1 active_ind after reset", int'(active_ind), 0);
      chk("R1 hold after reset", int'(hold), 0);

      // revertive mode (R2 code 2)
      wc(4 * WIN);
      chk("R5 no alarm with live refs", int'(alarm_a | alarm_b), 0);
      chk("R7 A selected", int'(mux_sel), 0);
      en_a = 1'b0;
      wc(3 * WIN);
      chk("R5 alarm_a after stop", int'(alarm_a), 1);
      chk("R7 failover to B", int'(mux_sel), 1);
      chk("R11 indicator shows B", int'(active_ind), 1);
      chk("R9 no hold single fail", int'(hold), 0);
      en_a = 1'b1;
      wc(WIN);
      chk("R6 alarm_a latched during reval", int'(alarm_a), 1);
      wc(5 * WIN);
      chk("R6 alarm_a cleared", int'(alarm_a), 0);
      chk("R7 reverted to A", int'(mux_sel), 0);

      // non-revertive mode (R2 code 1)
      mode_code = 2'd1;
      en_a = 1'b0;
      wc(3 * WIN);
      chk("R8 failover to B", int'(mux_sel), 1);
      en_a = 1'b1;
      wc(6 * WIN);
      chk("R6 alarm_a cleared nonrev", int'(alarm_a), 0);
      chk("R8 stays on B after A recovers", int'(mux_sel), 1);
      en_b = 1'b0;
      wc(3 * WIN);
      chk("R8 moves to A when B fails", int'(mux_sel), 0);
      en_b = 1'b1;
      wc(6 * WIN);
      chk("R6 alarm_b cleared", int'(alarm_b), 0);
      en_a = 1'b0;
      wc(3 * WIN);
      chk("R8 moves to B when A fails", int'(mux_sel), 1);
      en_b = 1'b0;
      wc(3 * WIN);
      chk("R9 hold on double fail", int'(hold), 1);
      chk("R10 indicator keeps B", int'(active_ind), 1);
      chk("R10 mux keeps B", int'(mux_sel), 1);
      en_a = 1'b1;
      wc(6 * WIN);
      chk("R9 hold released", int'(hold), 0);
      chk("R8 leaves failed B for A", int'(mux_sel), 0);
      en_b = 1'b1;
      wc(6 * WIN);

      // revalidation sweep in revertive mode
      mode_code = 2'd2;
      reval_case(0);
      reval_case(1);
      reval_case(2);
      reval_case(4);
      chk("R7 A kept during B sweep", int'(mux_sel), 0);

      // manual mode (R2 code 0)
      mode_code = 2'd0;
      man_sel = 1'b0;
      wc(20);
      chk("R3 manual selects A", int'(mux_sel), 0);
      for (int w = 1; w < DG; w++) begin
         man_sel = 1'b1;
         wc(w);
         man_sel = 1'b0;
         wc(DG + 6);
         chk("R4 short pulse rejected", int'(mux_sel), 0);
      end
      man_sel = 1'b1;
      wc(DG + 2);
      chk("R4 not accepted before latency", int'(mux_sel), 0);
      wc(2);
      chk("R4 accepted after latency", int'(mux_sel), 1);
      chk("R11 indicator follows manual", int'(active_ind), 1);
      en_b = 1'b0;
      wc(3 * WIN);
      chk("R5 alarm_b manual", int'(alarm_b), 1);
      chk("R3 manual ignores alarm", int'(mux_sel), 1);
      en_a = 1'b0;
      wc(3 * WIN);
      chk("R9 hold in manual", int'(hold), 1);

      // code 3 acts as manual
      mode_code = 2'd3;
      man_sel = 1'b0;
      wc(DG + 6);
      chk("R2 code 3 follows manual select", int'(mux_sel), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule